// File: doc/BRIEF.md
# Pipelined 8-bit Accumulator Processor Core

This core is a compact Harvard-style processor with an 8-bit data path. It reads one 16-bit word per clock from a program memory addressed by a 16-bit program counter. The low byte of each word is the instruction and the high byte is an immediate operand. Both bytes are registered, and the registered pair executes on the following clock. As a result, the word after any jump or branch always executes; this is the delay slot. The core uses a data memory with a 15-bit address. That memory has a combinational read and is written on the clock edge.

Each instruction carries three fields:

- **Operation:** bits 7..5 select the ALU function, a store or a jump.
- **Mode:** bits 4..2 select the data-memory address and the register that receives the result.
- **Source:** bits 1..0 select what drives the internal data bus.

Besides the accumulator, the core holds two index registers (X and Y), an output register and an extended output register. The extended output register samples the accumulator when bit 6 of the output register goes from 0 to 1.

The core has no sequencer states. Every clock performs the same transition: fetch the next word and execute the held word. Reset is the only other condition, and it forces that held word to zero.

Top module: `cpu8_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the held instruction, the held immediate, the accumulator, X, Y, the output register and the extended output. The first word executed after reset therefore loads zero into the accumulator, and no store happens while reset is held.
- R2: `rom_addr` equals the program counter. A word is executed on the clock edge after the one that fetches it. Every non-jump instruction advances the program counter by one, wrapping from 16'hFFFF to 16'h0000.
- R3: Outside jumps, the data address depends on the mode field:
  - Modes 0, 4, 5 and 6 use {8'h00, imm}.
  - Mode 1 uses {8'h00, X}.
  - Mode 2 uses {Y, imm}.
  - Modes 3 and 7 use {Y, X}.
  - Only the low 15 bits reach `ram_addr`.
- R4: The source field drives the bus: 0 selects the immediate, 1 selects the data-memory read, 2 selects the accumulator and 3 selects `in_port`.
- R5: The operation field selects the ALU result, truncated to 8 bits: 0 passes the bus, 1 gives acc AND bus, 2 gives acc OR bus, 3 gives acc XOR bus, 4 gives acc + bus, 5 gives acc - bus, and 6 passes acc.
- R6: The result goes to the accumulator in modes 0 to 3, to X in mode 4, to Y in mode 5, and to the output register in modes 6 and 7.
- R7: Operation 6 is a store. It writes the bus value to data memory at the mode's address. It leaves the accumulator or output register unchanged when the mode targets them, but X or Y still take the ALU result (the accumulator).
- R8: Mode 7, outside jumps, increments X by one (mod 256) after use. This applies to loads and stores alike.
- R9: Operation 7 with mode 0 is a far jump that sets the program counter to {Y, bus}.
- R10: Operation 7 with a nonzero mode is an in-page branch to {pc[15:8], bus}. The branch is taken when one of its enabled conditions holds:
  - Mode bit 0 enables "acc is positive and nonzero".
  - Mode bit 1 enables "acc[7] is set".
  - Mode bit 2 enables "acc is zero".
  - If the branch is not taken, the program counter advances by one.
- R11: The word that follows a jump or branch in program memory always executes, whether or not the branch is taken.
- R12: The extended output register samples the accumulator's value from before the instruction when a write to the output register turns bit 6 from 0 to 1. It holds its value in all other cases, including stores in modes 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rom_addr | output | 16 | Program memory address (program counter) |
| rom_data | input | 16 | Program word: [7:0] instruction, [15:8] immediate |
| ram_addr | output | 15 | Data memory address |
| ram_rdata | input | 8 | Data memory combinational read data |
| ram_wdata | output | 8 | Data memory write data |
| ram_we | output | 1 | Data memory write enable, taken on the rising edge |
| in_port | input | 8 | General input byte |
| out_port | output | 8 | Output register |
| xout_port | output | 8 | Extended output register |

## Verification
The assertions assume three things about the environment:

- Reset is high from time zero for at least one edge.
- `rom_data`, `ram_rdata` and `in_port` never carry unknown bits while the core can select them.
- The data memory returns, on the same cycle, the byte stored at the presented address.

The bench keeps to these assumptions in the following ways:

- Reset is raised before the first edge.
- Inputs change only on falling edges.
- Both memories are cleared before every program is loaded.
- Every program is loaded while reset is held.
- The test programs never store with the memory-read source, whose bus value is left undefined.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

    typedef enum logic [2:0] {
        OP_LD  = 3'd0,
        OP_AND = 3'd1,
        OP_OR  = 3'd2,
        OP_XOR = 3'd3,
        OP_ADD = 3'd4,
        OP_SUB = 3'd5,
        OP_ST  = 3'd6,
        OP_JMP = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        SRC_IMM = 2'd0,
        SRC_RAM = 2'd1,
        SRC_ACC = 2'd2,
        SRC_IN  = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        DST_ACC = 2'd0,
        DST_X   = 2'd1,
        DST_Y   = 2'd2,
        DST_OUT = 2'd3
    } dst_e;

    typedef enum logic [1:0] {
        AG_ZD = 2'd0,
        AG_ZX = 2'd1,
        AG_YD = 2'd2,
        AG_YX = 2'd3
    } agen_e;

    typedef struct packed {
        op_e        op;
        src_e       src;
        dst_e       dst;
        agen_e      agen;
        logic       is_store;
        logic       is_jump;
        logic       x_inc;
        logic       wr_dst;
        logic [2:0] cond;
    } ctrl_t;

endpackage

// File: rtl/cpu8_decode.sv
module cpu8_decode
    import cpu8_pkg::*;
(
    input  logic [7:0] instr,
    output ctrl_t      ctrl
);

    logic [2:0] mode;

    always_comb begin
        mode          = instr[4:2];
        ctrl.op       = op_e'(instr[7:5]);
        ctrl.src      = src_e'(instr[1:0]);
        ctrl.is_store = (instr[7:5] == 3'd6);
        ctrl.is_jump  = (instr[7:5] == 3'd7);
        ctrl.cond     = mode;
        ctrl.x_inc    = 1'b0;
        ctrl.agen     = AG_ZD;
        ctrl.dst      = DST_ACC;

        unique case (mode)
            3'd0: begin ctrl.agen = AG_ZD; ctrl.dst = DST_ACC; end
            3'd1: begin ctrl.agen = AG_ZX; ctrl.dst = DST_ACC; end
            3'd2: begin ctrl.agen = AG_YD; ctrl.dst = DST_ACC; end
            3'd3: begin ctrl.agen = AG_YX; ctrl.dst = DST_ACC; end
            3'd4: begin ctrl.agen = AG_ZD; ctrl.dst = DST_X;   end
            3'd5: begin ctrl.agen = AG_ZD; ctrl.dst = DST_Y;   end
            3'd6: begin ctrl.agen = AG_ZD; ctrl.dst = DST_OUT; end
            3'd7: begin ctrl.agen = AG_YX; ctrl.dst = DST_OUT; ctrl.x_inc = 1'b1; end
            default: begin ctrl.agen = AG_ZD; ctrl.dst = DST_ACC; end
        endcase

        // Jumps use the plain immediate address and write no register.
        if (ctrl.is_jump) begin
            ctrl.agen  = AG_ZD;
            ctrl.x_inc = 1'b0;
        end

        ctrl.wr_dst = !ctrl.is_jump &&
                      !(ctrl.is_store && (ctrl.dst == DST_ACC || ctrl.dst == DST_OUT));
    end

endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu
    import cpu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] bus,
    output logic [DATA_W-1:0] res
);

    always_comb begin
        unique case (op)
            OP_LD:   res = bus;
            OP_AND:  res = acc & bus;
            OP_OR:   res = acc | bus;
            OP_XOR:  res = acc ^ bus;
            OP_ADD:  res = acc + bus;
            OP_SUB:  res = acc - bus;
            OP_ST:   res = acc;
            OP_JMP:  res = DATA_W'(0) - acc;
            default: res = bus;
        endcase
    end

endmodule

// File: rtl/cpu8_nextpc.sv
module cpu8_nextpc #(
    parameter int DATA_W = 8,
    parameter int PC_W   = 2 * DATA_W
) (
    input  logic              is_jump,
    input  logic [2:0]        cond,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] yreg,
    input  logic [DATA_W-1:0] bus,
    input  logic [PC_W-1:0]   pc,
    output logic [PC_W-1:0]   pc_next
);

    localparam int PAGE_W = PC_W - DATA_W;

    logic acc_zero;
    logic acc_neg;
    logic taken;

    always_comb begin
        acc_zero = (acc == '0);
        acc_neg  = acc[DATA_W-1];
        // Condition index: 0 positive nonzero, 1 negative, 2 zero.
        unique case ({acc_zero, acc_neg})
            2'b00:   taken = cond[0];
            2'b01:   taken = cond[1];
            2'b10:   taken = cond[2];
            default: taken = 1'b0;
        endcase

        if (!is_jump) begin
            pc_next = pc + PC_W'(1);
        end else if (cond == 3'd0) begin
            pc_next = PC_W'({yreg, bus});
        end else if (taken) begin
            pc_next = {pc[PC_W-1 -: PAGE_W], bus};
        end else begin
            pc_next = pc + PC_W'(1);
        end
    end

endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
    import cpu8_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int PC_W     = 2 * DATA_W,
    parameter int RAM_AW   = 15,
    parameter int SYNC_BIT = 6
) (
    input  logic              clk,
    input  logic              rst,
    output logic [PC_W-1:0]   rom_addr,
    input  logic [PC_W-1:0]   rom_data,
    output logic [RAM_AW-1:0] ram_addr,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_we,
    input  logic [DATA_W-1:0] in_port,
    output logic [DATA_W-1:0] out_port,
    output logic [DATA_W-1:0] xout_port
);

    localparam int ADDR_W = 2 * DATA_W;

    logic [PC_W-1:0]   pc_q;
    logic [DATA_W-1:0] instr_q;
    logic [DATA_W-1:0] imm_q;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] xr_q;
    logic [DATA_W-1:0] yr_q;
    logic [DATA_W-1:0] out_q;
    logic [DATA_W-1:0] xout_q;

    ctrl_t             ctrl;
    logic [DATA_W-1:0] addr_hi;
    logic [DATA_W-1:0] addr_lo;
    logic [ADDR_W-1:0] addr_full;
    logic [DATA_W-1:0] bus_w;
    logic [DATA_W-1:0] alu_w;
    logic [PC_W-1:0]   pc_next;
    logic [DATA_W-1:0] rise_w;
    logic              out_wr;

    cpu8_decode u_dec (
        .instr (instr_q[7:0]),
        .ctrl  (ctrl)
    );

    // Address generation
    always_comb begin
        addr_hi   = (ctrl.agen == AG_YD || ctrl.agen == AG_YX) ? yr_q : '0;
        addr_lo   = (ctrl.agen == AG_ZX || ctrl.agen == AG_YX) ? xr_q : imm_q;
        addr_full = {addr_hi, addr_lo};
    end

    // Bus source selection
    always_comb begin
        unique case (ctrl.src)
            SRC_IMM: bus_w = imm_q;
            SRC_RAM: bus_w = ctrl.is_store ? '0 : ram_rdata;
            SRC_ACC: bus_w = acc_q;
            SRC_IN:  bus_w = in_port;
            default: bus_w = imm_q;
        endcase
    end

    cpu8_alu #(.DATA_W(DATA_W)) u_alu (
        .op  (ctrl.op),
        .acc (acc_q),
        .bus (bus_w),
        .res (alu_w)
    );

    cpu8_nextpc #(.DATA_W(DATA_W), .PC_W(PC_W)) u_npc (
        .is_jump (ctrl.is_jump),
        .cond    (ctrl.cond),
        .acc     (acc_q),
        .yreg    (yr_q),
        .bus     (bus_w),
        .pc      (pc_q),
        .pc_next (pc_next)
    );

    always_comb begin
        out_wr = ctrl.wr_dst && (ctrl.dst == DST_OUT);
        rise_w = ~out_q & alu_w;
    end

    // Fetch/execute register update
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            instr_q <= '0;
            imm_q   <= '0;
            acc_q   <= '0;
            xr_q    <= '0;
            yr_q    <= '0;
            out_q   <= '0;
            xout_q  <= '0;
        end else begin
            pc_q    <= pc_next;
            instr_q <= rom_data[DATA_W-1:0];
            imm_q   <= rom_data[PC_W-1 -: DATA_W];
            if (ctrl.wr_dst) begin
                unique case (ctrl.dst)
                    DST_ACC: acc_q <= alu_w;
                    DST_X:   xr_q  <= alu_w;
                    DST_Y:   yr_q  <= alu_w;
                    DST_OUT: out_q <= alu_w;
                    default: acc_q <= alu_w;
                endcase
            end
            if (ctrl.x_inc) begin
                xr_q <= xr_q + DATA_W'(1);
            end
            if (out_wr && rise_w[SYNC_BIT]) begin
                xout_q <= acc_q;
            end
        end
    end

    always_comb begin
        rom_addr  = pc_q;
        ram_addr  = addr_full[RAM_AW-1:0];
        ram_wdata = bus_w;
        ram_we    = ctrl.is_store;
        out_port  = out_q;
        xout_port = xout_q;
    end

    // R2: non-jump instructions advance the counter by one
    a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
        (instr_q[7:5] != 3'd7) |=> (pc_q == $past(pc_q) + PC_W'(1)));

    // R7: stores leave the accumulator untouched
    a_r7_store_keeps_acc: assert property (@(posedge clk) disable iff (rst)
        (instr_q[7:5] == 3'd6) |=> (acc_q == $past(acc_q)));

    // R8: mode 7 outside jumps post-increments X
    a_r8_x_postinc: assert property (@(posedge clk) disable iff (rst)
        (instr_q[7:5] != 3'd7 && instr_q[4:2] == 3'd7) |=> (xr_q == $past(xr_q) + DATA_W'(1)));

    // R9: far jump lands on {Y, bus}
    a_r9_far_jump: assert property (@(posedge clk) disable iff (rst)
        (instr_q[7:2] == 6'b111000) |=> (pc_q == PC_W'({$past(yr_q), $past(bus_w)})));

    // R12: extended output only moves when output bit 6 rises
    a_r12_xout_hold: assert property (@(posedge clk) disable iff (rst)
        !$rose(out_q[SYNC_BIT]) |-> $stable(xout_q));

endmodule

// File: tb/cpu8_core_tb_top.sv
module cpu8_core_tb_top;

    logic        clk;
    logic        rst;
    logic [15:0] rom_addr;
    logic [15:0] rom_data;
    logic [14:0] ram_addr;
    logic [7:0]  ram_rdata;
    logic [7:0]  ram_wdata;
    logic        ram_we;
    logic [7:0]  in_port;
    logic [7:0]  out_port;
    logic [7:0]  xout_port;

    logic [15:0] rom_m [512];
    logic [7:0]  ram_m [512];

    int n_chk  = 0;
    int n_fail = 0;

    cpu8_core dut_i (
        .clk       (clk),
        .rst       (rst),
        .rom_addr  (rom_addr),
        .rom_data  (rom_data),
        .ram_addr  (ram_addr),
        .ram_rdata (ram_rdata),
        .ram_wdata (ram_wdata),
        .ram_we    (ram_we),
        .in_port   (in_port),
        .out_port  (out_port),
        .xout_port (xout_port)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    assign rom_data  = rom_m[rom_addr[8:0]];
    assign ram_rdata = ram_m[ram_addr[8:0]];

    always @(posedge clk) begin
        if (ram_we) ram_m[ram_addr[8:0]] <= ram_wdata;
    end

    function automatic logic [15:0] enc(input logic [2:0] op, input logic [2:0] md,
                                        input logic [1:0] bs, input logic [7:0] imm);
        return {imm, op, md, bs};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Hold reset, clear memories; program is loaded by caller afterwards.
    task automatic enter_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < 512; i++) begin
            rom_m[i] = 16'h0000;
            ram_m[i] = 8'h00;
        end
    endtask

    task automatic leave_reset();
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // R1 / R2: reset state and first executed word
    task automatic t_reset();
        enter_reset();
        rom_m[0]     = enc(3'd6, 3'd0, 2'd2, 8'h10);
        ram_m[9'h10] = 8'hAA;
        @(negedge clk);
        chk("R1 rom_addr in reset", rom_addr, 16'h0000);
        chk("R1 out_port in reset", {8'h0, out_port}, 16'h0000);
        chk("R1 xout_port in reset", {8'h0, xout_port}, 16'h0000);
        chk("R1 no store in reset", {15'h0, ram_we}, 16'h0000);
        leave_reset();
        run(1);
        chk("R2 pc after one edge", rom_addr, 16'h0001);
        run(1);
        chk("R1 first word loads zero", {8'h0, ram_m[9'h10]}, 16'h0000);
    endtask

    // R4 / R5: bus sources and ALU operations
    task automatic t_alu();
        enter_reset();
        in_port = 8'h7E;
        ram_m[9'h40] = 8'h91;
        rom_m[0]  = enc(3'd0, 3'd0, 2'd0, 8'h5C);
        rom_m[1]  = enc(3'd1, 3'd0, 2'd0, 8'h0F);
        rom_m[2]  = enc(3'd6, 3'd0, 2'd2, 8'h20);
        rom_m[3]  = enc(3'd2, 3'd0, 2'd0, 8'h30);
        rom_m[4]  = enc(3'd3, 3'd0, 2'd0, 8'hFF);
        rom_m[5]  = enc(3'd4, 3'd0, 2'd0, 8'h50);
        rom_m[6]  = enc(3'd6, 3'd0, 2'd2, 8'h21);
        rom_m[7]  = enc(3'd5, 3'd0, 2'd0, 8'h20);
        rom_m[8]  = enc(3'd6, 3'd0, 2'd2, 8'h22);
        rom_m[9]  = enc(3'd0, 3'd0, 2'd3, 8'h00);
        rom_m[10] = enc(3'd6, 3'd0, 2'd2, 8'h23);
        rom_m[11] = enc(3'd0, 3'd0, 2'd1, 8'h40);
        rom_m[12] = enc(3'd4, 3'd0, 2'd2, 8'h00);
        rom_m[13] = enc(3'd6, 3'd0, 2'd2, 8'h24);
        leave_reset();
        run(16);
        chk("R5 and", {8'h0, ram_m[9'h20]}, 16'h000C);
        chk("R5 or/xor/add wrap", {8'h0, ram_m[9'h21]}, 16'h0013);
        chk("R5 sub wrap", {8'h0, ram_m[9'h22]}, 16'h00F3);
        chk("R4 in_port source", {8'h0, ram_m[9'h23]}, 16'h007E);
        chk("R4 ram and acc sources", {8'h0, ram_m[9'h24]}, 16'h0022);
    endtask

    // R3 / R6 / R8: addressing modes, destinations, post-increment
    task automatic t_modes();
        enter_reset();
        ram_m[9'h032] = 8'h44;
        ram_m[9'h132] = 8'h55;
        rom_m[0]  = enc(3'd0, 3'd4, 2'd0, 8'h30);
        rom_m[1]  = enc(3'd0, 3'd5, 2'd0, 8'h01);
        rom_m[2]  = enc(3'd0, 3'd0, 2'd0, 8'h77);
        rom_m[3]  = enc(3'd6, 3'd1, 2'd2, 8'h00);
        rom_m[4]  = enc(3'd6, 3'd2, 2'd2, 8'h05);
        rom_m[5]  = enc(3'd6, 3'd3, 2'd2, 8'h00);
        rom_m[6]  = enc(3'd6, 3'd7, 2'd0, 8'h99);
        rom_m[7]  = enc(3'd6, 3'd7, 2'd0, 8'h9A);
        rom_m[8]  = enc(3'd0, 3'd1, 2'd1, 8'h00);
        rom_m[9]  = enc(3'd0, 3'd3, 2'd1, 8'h00);
        rom_m[10] = enc(3'd6, 3'd1, 2'd2, 8'h00);
        rom_m[11] = enc(3'd0, 3'd6, 2'd0, 8'h21);
        rom_m[12] = enc(3'd0, 3'd7, 2'd2, 8'h00);
        rom_m[13] = enc(3'd6, 3'd1, 2'd2, 8'h00);
        leave_reset();
        run(16);
        chk("R3 mode1 {0,X}", {8'h0, ram_m[9'h030]}, 16'h0077);
        chk("R3 mode2 {Y,imm}", {8'h0, ram_m[9'h105]}, 16'h0077);
        chk("R3 mode3/7 {Y,X}", {8'h0, ram_m[9'h130]}, 16'h0099);
        chk("R8 store post-increment", {8'h0, ram_m[9'h131]}, 16'h009A);
        chk("R6 loads via X and Y,X", {8'h0, ram_m[9'h032]}, 16'h0055);
        chk("R8 load post-increment", {8'h0, ram_m[9'h033]}, 16'h0055);
        chk("R6 mode7 to out_port", {8'h0, out_port}, 16'h0055);
    endtask

    // R7: store side effects
    task automatic t_store();
        enter_reset();
        ram_m[9'h011] = 8'hEE;
        rom_m[0] = enc(3'd0, 3'd0, 2'd0, 8'h11);
        rom_m[1] = enc(3'd0, 3'd6, 2'd0, 8'h0F);
        rom_m[2] = enc(3'd6, 3'd6, 2'd0, 8'h50);
        rom_m[3] = enc(3'd6, 3'd4, 2'd0, 8'h51);
        rom_m[4] = enc(3'd6, 3'd0, 2'd0, 8'h60);
        rom_m[5] = enc(3'd6, 3'd1, 2'd2, 8'h00);
        leave_reset();
        run(8);
        chk("R7 store keeps out_port", {8'h0, out_port}, 16'h000F);
        chk("R7 store writes bus mode6", {8'h0, ram_m[9'h050]}, 16'h0050);
        chk("R7 store writes bus mode4", {8'h0, ram_m[9'h051]}, 16'h0051);
        chk("R7 store writes bus mode0", {8'h0, ram_m[9'h060]}, 16'h0060);
        chk("R7 X takes acc, acc kept", {8'h0, ram_m[9'h011]}, 16'h0011);
    endtask

    // R9 / R10 / R11: branches, far jump, delay slots
    task automatic t_branch();
        enter_reset();
        ram_m[9'h73] = 8'hEE;
        ram_m[9'h75] = 8'hEE;
        ram_m[9'h77] = 8'hEE;
        ram_m[9'h7A] = 8'hEE;
        rom_m[0]  = enc(3'd0, 3'd0, 2'd0, 8'h05);
        rom_m[1]  = enc(3'd7, 3'd1, 2'd0, 8'h05);
        rom_m[2]  = enc(3'd6, 3'd0, 2'd2, 8'h70);
        rom_m[3]  = enc(3'd6, 3'd0, 2'd2, 8'h71);
        rom_m[5]  = enc(3'd7, 3'd2, 2'd0, 8'h09);
        rom_m[6]  = enc(3'd0, 3'd0, 2'd0, 8'h80);
        rom_m[7]  = enc(3'd6, 3'd0, 2'd2, 8'h72);
        rom_m[8]  = enc(3'd7, 3'd2, 2'd0, 8'h0C);
        rom_m[9]  = enc(3'd0, 3'd0, 2'd0, 8'h00);
        rom_m[10] = enc(3'd6, 3'd0, 2'd2, 8'h73);
        rom_m[12] = enc(3'd7, 3'd4, 2'd0, 8'h10);
        rom_m[13] = enc(3'd6, 3'd0, 2'd2, 8'h74);
        rom_m[14] = enc(3'd6, 3'd0, 2'd2, 8'h75);
        rom_m[16] = enc(3'd7, 3'd3, 2'd0, 8'h14);
        rom_m[17] = enc(3'd0, 3'd0, 2'd0, 8'h01);
        rom_m[18] = enc(3'd6, 3'd0, 2'd2, 8'h76);
        rom_m[19] = enc(3'd0, 3'd5, 2'd0, 8'h01);
        rom_m[20] = enc(3'd7, 3'd0, 2'd0, 8'h08);
        rom_m[21] = enc(3'd0, 3'd0, 2'd0, 8'h3C);
        rom_m[22] = enc(3'd6, 3'd0, 2'd2, 8'h77);
        rom_m[9'h108] = enc(3'd6, 3'd0, 2'd2, 8'h78);
        rom_m[9'h109] = enc(3'd7, 3'd7, 2'd0, 8'h20);
        rom_m[9'h10A] = enc(3'd0, 3'd0, 2'd0, 8'h42);
        rom_m[9'h10B] = enc(3'd6, 3'd0, 2'd2, 8'h7A);
        rom_m[9'h120] = enc(3'd6, 3'd0, 2'd2, 8'h79);
        leave_reset();
        run(30);
        chk("R11 delay slot after taken branch", {8'h0, ram_m[9'h70]}, 16'h0005);
        chk("R10 not-taken negative test falls through", {8'h0, ram_m[9'h72]}, 16'h0080);
        chk("R10 taken on negative skips", {8'h0, ram_m[9'h73]}, 16'h00EE);
        chk("R11 delay slot after zero branch", {8'h0, ram_m[9'h74]}, 16'h0000);
        chk("R10 taken on zero skips", {8'h0, ram_m[9'h75]}, 16'h00EE);
        chk("R10 nonzero test falls through", {8'h0, ram_m[9'h76]}, 16'h0001);
        chk("R9 far jump skips next", {8'h0, ram_m[9'h77]}, 16'h00EE);
        chk("R9 far jump target {Y,imm}", {8'h0, ram_m[9'h78]}, 16'h003C);
        chk("R10 always branch in page", {8'h0, ram_m[9'h79]}, 16'h0042);
        chk("R10 always branch skips", {8'h0, ram_m[9'h7A]}, 16'h00EE);
    endtask

    // R12: extended output capture
    task automatic t_xout();
        enter_reset();
        rom_m[0] = enc(3'd0, 3'd0, 2'd0, 8'h5A);
        rom_m[1] = enc(3'd0, 3'd6, 2'd0, 8'h40);
        rom_m[2] = enc(3'd0, 3'd0, 2'd0, 8'h33);
        rom_m[3] = enc(3'd0, 3'd6, 2'd0, 8'hC0);
        rom_m[4] = enc(3'd0, 3'd6, 2'd0, 8'h00);
        rom_m[5] = enc(3'd0, 3'd4, 2'd0, 8'h40);
        rom_m[6] = enc(3'd0, 3'd6, 2'd2, 8'h00);
        rom_m[7] = enc(3'd6, 3'd6, 2'd0, 8'h40);
        rom_m[8] = enc(3'd0, 3'd6, 2'd0, 8'h47);
        leave_reset();
        run(9);
        chk("R12 held without rising bit 6", {8'h0, xout_port}, 16'h005A);
        chk("R12 out after store unchanged", {8'h0, out_port}, 16'h0033);
        run(1);
        chk("R12 capture on rising bit 6", {8'h0, xout_port}, 16'h0033);
        chk("R6 out_port written", {8'h0, out_port}, 16'h0047);
    endtask

    // R2 / R9: far jump to top of space and wrap
    task automatic t_wrap();
        enter_reset();
        rom_m[0] = enc(3'd0, 3'd5, 2'd0, 8'hFF);
        rom_m[1] = enc(3'd7, 3'd0, 2'd0, 8'hFF);
        leave_reset();
        run(3);
        chk("R9 far jump to FFFF", rom_addr, 16'hFFFF);
        run(1);
        chk("R2 pc wraps to zero", rom_addr, 16'h0000);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst     = 1'b1;
        in_port = 8'h00;
        t_reset();
        t_alu();
        t_modes();
        t_store();
        t_branch();
        t_xout();
        t_wrap();
        summary();
        $finish;
    end

endmodule